// File: doc/BRIEF.md
# Quadrature Decoder Position Counter

This block turns a pair of encoder signals into a bounded position count. The count runs between 0 and a programmable maximum. Stepping up past the maximum wraps it to 0, and stepping down past 0 wraps it to the maximum. Either wrap raises a sticky overflow flag and records which end of the range was crossed.

Two encodings are accepted. In the phase mode the two inputs are a Gray-coded quadrature pair. Every legal transition on either input moves the count by one, which gives four counts per encoder cycle, and the order of the transitions gives the direction. In the count/direction mode one input is a count pulse and the other gives the sense of the step.

Both encoder inputs are brought into the clock domain through a two-flop synchronizer before they are decoded. An enable input gates all counting. The direction of the most recent step is always visible on an output.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 1, and the overflow flag and the overflow-side bit are both 0.
- R2: While the enable input is 0, transitions on the encoder inputs leave the count, the direction and the flags unchanged. Setting the enable back to 1 produces no step from transitions that happened while it was 0.
- R3: In phase mode (mode input 0), with the inputs written as {a, b}, each transition in the order 00→01→11→10→00 adds one to the count. Each transition in the reverse order subtracts one.
- R4: In phase mode, a change of both inputs between two samples is ignored. The count and the direction stay as they were.
- R5: In count/direction mode (mode input 1), each rising edge of input a changes the count by one. The count goes up if input b is 1 and down if input b is 0. Falling edges of a and any change of b do not count.
- R6: The direction output holds the sense of the latest step: 1 for up, 0 for down.
- R7: An up step from the maximum (or from any value above it) gives a count of 0, sets the overflow flag and sets the overflow-side bit to 1.
- R8: A down step from 0 gives a count equal to the maximum, sets the overflow flag and sets the overflow-side bit to 0.
- R9: The overflow flag stays set until a clear strobe. If a wrap and a clear fall in the same cycle, the flag ends up set. The overflow-side bit is not affected by a clear and keeps its value until the next wrap.
- R10: A change on the encoder inputs appears on the count on the third rising clock edge after it. It is not yet visible after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Decoder enable |
| mode_i | input | 1 | 0 = phase encoding, 1 = count/direction encoding |
| phase_a_i | input | 1 | Encoder input a (asynchronous) |
| phase_b_i | input | 1 | Encoder input b (asynchronous) |
| max_i | input | CNT_W | Largest value the count can hold |
| ovf_clr_i | input | 1 | Strobe that clears the overflow flag |
| count_o | output | CNT_W | Position count |
| dir_o | output | 1 | Direction of the latest step, 1 = up |
| ovf_o | output | 1 | Sticky overflow flag |
| ovf_top_o | output | 1 | 1 = latest wrap was at the top, 0 = at the bottom |

## Verification
An input change passes two synchronizer flops and then the state register. Its effect on the count, the direction and the flags is therefore due on the third rising edge after the change. The bench drives at falling edges and, in the latency test, samples both after the second edge and after the third. In every other sweep it waits five falling edges before it compares, so every result has settled. The test of a clear landing in the same cycle as a wrap raises the clear exactly in the cycle between the second and the third edge, which is the cycle in which the step is decoded.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

    typedef enum logic {
        ENC_PHASE  = 1'b0,
        ENC_CNTDIR = 1'b1
    } enc_mode_e;

    // One decoded step request
    typedef struct packed {
        logic valid;
        logic up;
    } step_t;

endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                chain_q[i] <= chain_d[i];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/qpc_step_decode.sv
module qpc_step_decode
    import qpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  enc_mode_e  mode_i,
    input  logic [1:0] ab_i,      // {a, b}, already synchronized
    output step_t      step_o
);
    typedef struct packed {
        logic [1:0] prev;
    } dec_state_t;

    dec_state_t st_d, st_q;
    step_t      step_d;
    logic       a_cur, b_cur, a_prv;
    logic [1:0] delta;

    assign a_cur = ab_i[1];
    assign b_cur = ab_i[0];
    assign a_prv = st_q.prev[1];
    assign delta = ab_i ^ st_q.prev;

    always_comb begin
        st_d.prev = ab_i;   // history follows the inputs even while disabled
        step_d    = '0;
        if (en_i) begin
            if (mode_i == ENC_PHASE) begin
                // exactly one input moved: legal Gray transition
                if (delta == 2'b01 || delta == 2'b10) begin
                    step_d.valid = 1'b1;
                    step_d.up    = a_prv ^ b_cur;
                end
            end else begin
                if (a_cur && !a_prv) begin
                    step_d.valid = 1'b1;
                    step_d.up    = b_cur;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step_o = step_d;

    // R4: a two-bit jump in phase mode never yields a step
    p_illegal_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ENC_PHASE && ab_i == ~st_q.prev) |-> !step_o.valid);

    // R5: with input a low, count/direction mode yields no step
    p_cd_no_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == ENC_CNTDIR && !a_cur) |-> !step_o.valid);

endmodule

// File: rtl/qpc_position.sv
module qpc_position
    import qpc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_t            step_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             ovf_o,
    output logic             ovf_top_o
);
    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic             dir;
        logic             ovf;
        logic             top;
    } pos_state_t;

    pos_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.ovf = 1'b0;
        end
        if (step_i.valid) begin
            st_d.dir = step_i.up;
            if (step_i.up) begin
                if (st_q.count >= max_i) begin
                    st_d.count = ZERO;
                    st_d.ovf   = 1'b1;
                    st_d.top   = 1'b1;
                end else begin
                    st_d.count = st_q.count + ONE;
                end
            end else begin
                if (st_q.count == ZERO) begin
                    st_d.count = max_i;
                    st_d.ovf   = 1'b1;
                    st_d.top   = 1'b0;
                end else begin
                    st_d.count = st_q.count - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o   = st_q.count;
    assign dir_o     = st_q.dir;
    assign ovf_o     = st_q.ovf;
    assign ovf_top_o = st_q.top;

    // R7: up step at the maximum wraps to zero and marks the top side
    p_wrap_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i.valid && step_i.up && count_o == max_i)
        |=> (count_o == ZERO && ovf_o && ovf_top_o));

    // R8: down step at zero wraps to the maximum and marks the bottom side
    p_wrap_bottom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i.valid && !step_i.up && count_o == ZERO)
        |=> (count_o == $past(max_i) && ovf_o && !ovf_top_o));

    // R9: the flag only drops on a clear
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o);

    // R9: the side bit moves only with a step
    p_side_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i.valid |=> $stable(ovf_top_o));

    // R6: direction follows the latest step
    p_dir_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        step_i.valid |=> (dir_o == $past(step_i.up)));

endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             phase_a_i,
    input  logic             phase_b_i,
    input  logic [CNT_W-1:0] max_i,
    input  logic             ovf_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             dir_o,
    output logic             ovf_o,
    output logic             ovf_top_o
);
    logic [1:0] ab_sync;
    step_t      step;
    enc_mode_e  mode;

    assign mode = enc_mode_e'(mode_i);

    qpc_sync #(
        .STAGES (SYNC_STAGES),
        .W      (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({phase_a_i, phase_b_i}),
        .sync_o  (ab_sync)
    );

    qpc_step_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .mode_i (mode),
        .ab_i   (ab_sync),
        .step_o (step)
    );

    qpc_position #(
        .CNT_W (CNT_W)
    ) u_position (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .max_i     (max_i),
        .clr_i     (ovf_clr_i),
        .count_o   (count_o),
        .dir_o     (dir_o),
        .ovf_o     (ovf_o),
        .ovf_top_o (ovf_top_o)
    );

    // R2: a disabled cycle never moves the count
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(count_o));

endmodule

// File: tb/tb_quad_pos_counter.sv
module tb_quad_pos_counter;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         mode = 1'b0;
    logic         pa = 1'b0;
    logic         pb = 1'b0;
    logic [W-1:0] maxv = 4'd5;
    logic         clr = 1'b0;
    logic [W-1:0] count;
    logic         dir, ovf, top;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    int   m_cnt = 0;
    bit   m_dir = 1'b1;
    bit   m_ovf = 1'b0;
    bit   m_top = 1'b0;
    bit   m_a = 1'b0;
    bit   m_b = 1'b0;

    always #2 clk = ~clk;

    quad_pos_counter #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode),
        .phase_a_i(pa), .phase_b_i(pb), .max_i(maxv), .ovf_clr_i(clr),
        .count_o(count), .dir_o(dir), .ovf_o(ovf), .ovf_top_o(top)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_all(string req);
        check({req, " count"}, int'(count), m_cnt);
        check("R6 dir", int'(dir), int'(m_dir));
        check("R9 ovf", int'(ovf), int'(m_ovf));
        check("R9 side", int'(top), int'(m_top));
    endtask

    // quadrature position of {a,b}: 00->0, 01->1, 11->2, 10->3
    function automatic int qpos(bit a, bit b);
        return a ? (b ? 2 : 3) : (b ? 1 : 0);
    endfunction

    // returns 1 if the step wraps
    function automatic bit model_step(bit up);
        bit w = 1'b0;
        m_dir = up;
        if (up) begin
            if (m_cnt >= int'(maxv)) begin
                m_cnt = 0; m_ovf = 1'b1; m_top = 1'b1; w = 1'b1;
            end else m_cnt++;
        end else begin
            if (m_cnt == 0) begin
                m_cnt = int'(maxv); m_ovf = 1'b1; m_top = 1'b0; w = 1'b1;
            end else m_cnt--;
        end
        return w;
    endfunction

    // update the model for a new input pair; returns a tag for the count check
    function automatic string model_inputs(bit a, bit b);
        string tag = "R2";
        if (en) begin
            if (!mode) begin
                int d = (qpos(a, b) - qpos(m_a, m_b) + 4) % 4;
                tag = "R3";
                if (d == 2) tag = "R4";
                else if (d == 1) begin if (model_step(1'b1)) tag = "R7"; end
                else if (d == 3) begin if (model_step(1'b0)) tag = "R8"; end
            end else begin
                tag = "R5";
                if (a && !m_a) begin
                    if (model_step(b)) tag = b ? "R7" : "R8";
                end
            end
        end
        m_a = a; m_b = b;
        return tag;
    endfunction

    task automatic drive(bit a, bit b);
        string tag = model_inputs(a, b);
        pa = a; pb = b;
        repeat (5) @(negedge clk);
        compare_all(tag);
    endtask

    // one phase-mode step in the given sense
    task automatic phase_step(bit up);
        int p = qpos(m_a, m_b);
        int n = up ? (p + 1) % 4 : (p + 3) % 4;
        case (n)
            0: drive(1'b0, 1'b0);
            1: drive(1'b0, 1'b1);
            2: drive(1'b1, 1'b1);
            default: drive(1'b1, 1'b0);
        endcase
    endtask

    task automatic clear_flag();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_ovf = 1'b0;
        @(negedge clk);
        compare_all("R9");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 dir", int'(dir), 1);
        check("R1 ovf", int'(ovf), 0);
        check("R1 side", int'(top), 0);
        rst_n = 1'b1;
        en = 1'b1;
        @(negedge clk);

        // R10 latency: 00 -> 01 is an up step
        void'(model_inputs(1'b0, 1'b1));
        pa = 1'b0; pb = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R10 after two edges", int'(count), 0);
        @(negedge clk);
        check("R10 after three edges", int'(count), 1);
        repeat (3) @(negedge clk);
        compare_all("R10");

        // phase-mode sweeps over several maxima, both directions
        foreach (maxv_list[k]) begin
            maxv = maxv_list[k];
            @(negedge clk);
            for (int i = 0; i < 2 * (int'(maxv) + 1) + 3; i++) phase_step(1'b1);
            clear_flag();
            for (int i = 0; i < 2 * (int'(maxv) + 1) + 3; i++) phase_step(1'b0);
            clear_flag();
        end

        // R4: two-bit jumps from each state
        maxv = 4'd9;
        @(negedge clk);
        phase_step(1'b1);
        for (int i = 0; i < 4; i++) begin
            drive(!m_a, !m_b);
            phase_step(i[0]);
        end

        // R2: transitions while disabled, then re-enable
        en = 1'b0;
        for (int i = 0; i < 6; i++) phase_step(1'b1);
        en = 1'b1;
        repeat (5) @(negedge clk);
        compare_all("R2");
        phase_step(1'b0);

        // R9: wrap coinciding with clear keeps the flag set
        maxv = 4'd3;
        @(negedge clk);
        while (m_cnt != 3) phase_step(1'b1);
        clear_flag();
        begin
            int p = (qpos(m_a, m_b) + 1) % 4;
            bit na = (p == 2 || p == 3);
            bit nb = (p == 1 || p == 2);
            void'(model_inputs(na, nb));
            pa = na; pb = nb;
            @(posedge clk); @(posedge clk); @(negedge clk);
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            repeat (3) @(negedge clk);
            compare_all("R9");
        end
        clear_flag();

        // R5: count/direction mode
        mode = 1'b1;
        maxv = 4'd4;
        drive(1'b0, m_b);
        drive(1'b0, 1'b1);
        for (int i = 0; i < 7; i++) begin
            drive(1'b1, 1'b1);
            drive(1'b0, 1'b1);
        end
        drive(1'b0, 1'b0);
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b0);
            drive(1'b1, 1'b1);
            drive(1'b0, 1'b1);
            drive(1'b0, 1'b0);
        end
        clear_flag();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    logic [W-1:0] maxv_list [3] = '{4'd5, 4'd0, 4'd15};

endmodule